// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog peripheral on a simple register bus. Software starts it, services it and stops it by writing a control word. Each control word is accepted only if it completes a two-write unlock handshake. The first write places an opening key in an 8-bit key field. The very next control write must place a commit key in that field, and that commit write carries the complete new configuration: enable, prescaler code, warning code and reload value. Any other control write cancels the handshake. After every accepted commit the handshake must start again from the beginning.

While the watchdog is enabled, a 16-bit counter loaded from the reload value counts down once per prescaled tick. When the counter steps down past a warning threshold, the block raises a one-cycle warning interrupt. When the counter runs out, the block stops itself, holds a reset request for a fixed number of cycles and sets a cause flag. The cause flag lives in the power-on reset domain, so it survives the system reset that the request triggers. Software can read it from the status register after the reboot.

Top module: `pwd_watchdog`

## Requirements
- R1: After power-on and system reset, both registers read zero, and `warn_irq` and `rst_req` are low.
- R2: A control write at offset 0x0 is applied only when it carries key 0xDC in bits 23:16 and the immediately preceding control write carried key 0xBE in bits 23:16. The commit write itself supplies the new settings.
- R3: The unlock is lost in two cases: a control write without the opening key, or a write after the opening key that does not carry the commit key. Such writes change nothing. Every accepted commit re-locks the register, so a following lone commit-key write is ignored.
- R4: Control layout: bit 31 enable, bits 27:26 warning code, bits 25:24 prescaler code, bits 15:0 reload; reads return the key field as zero. Status at offset 0x8: bit 31 running, bit 30 watchdog-reset cause, bits 15:0 current count. Writes to the status offset have no effect.
- R5: Prescaler codes 0, 1, 2 and 3 give one counter decrement every 1, 64, 4096 and 262144 clock cycles. The prescaler restarts from zero on every accepted commit.
- R6: The warning limit is 32768 >> warning code (code 3 gives 4096). `warn_irq` pulses high for one cycle when a tick moves the counter from the limit down to one below it.
- R7: An accepted commit with enable set loads the counter with the reload value and restarts the countdown. This replaces all settings even while the watchdog is already running.
- R8: An accepted commit with enable clear stops the watchdog. The counter then holds the loaded value.
- R9: When a tick finds the counter at 1 or 0, the counter ends at 0, the watchdog stops, `rst_req` goes high for RST_CYCLES cycles (default 4), and the cause flag sets.
- R10: The cause flag is unaffected by `rst_n` and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset (also clears the cause flag and reset pulse) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| warn_irq | output | 1 | One-cycle pre-warning pulse |
| rst_req | output | 1 | Reset request, held RST_CYCLES cycles on expiry |

## Verification
The bench breaks the handshake in several ways: a lone commit key, a wrong second key, and a commit right after an accepted one. A design that latched the state on the wrong write would change the control readback. Prescaler codes are checked one cycle before and at the expected decrement, so an off-by-one divider or a prescaler that is not restarted on a service shows up at once. The warning and expiry checks sample the cycle before, the cycle of and the cycle after each event, which catches pulses that are too long or in the wrong cycle, a reload of zero that never expires, and a reset request of the wrong length. The cause flag is checked across a system reset and then across a power-on reset, which exposes a flag placed in the wrong reset domain.

// File: rtl/pwd_wdt_pkg.sv
// Package: shared field positions, key values and the unlock state type.
// Assumes a 32-bit register bus and a reload field no wider than 16 bits.
package pwd_wdt_pkg;
    localparam int REG_W     = 32;
    localparam int KEY_W     = 8;
    localparam int KEY_LSB   = 16;
    localparam int CODE_W    = 2;
    localparam int PSC_LSB   = 24;
    localparam int WARN_LSB  = 26;
    localparam int CAUSE_BIT = 30;
    localparam int EN_BIT    = 31;

    localparam logic [KEY_W-1:0] KEY_OPEN   = 8'hBE;
    localparam logic [KEY_W-1:0] KEY_COMMIT = 8'hDC;

    typedef enum logic {
        ULK_IDLE,
        ULK_ARMED
    } ulk_state_e;
endpackage

// File: rtl/pwd_wdt_unlock.sv
// Unlock sequencer: tracks the two-write key handshake on control writes.
// accept is high in the cycle of a commit write that directly follows an
// opening write. Assumes ctrl_wr is a single-cycle strobe per write.
module pwd_wdt_unlock
    import pwd_wdt_pkg::*;
#(
    parameter int               KW         = 8,
    parameter logic [KW-1:0]    OPEN_KEY   = 8'hBE,
    parameter logic [KW-1:0]    COMMIT_KEY = 8'hDC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [KW-1:0] key,
    output logic          accept
);
    ulk_state_e state_q;

    assign accept = ctrl_wr && (state_q == ULK_ARMED) && (key == COMMIT_KEY);

    // Arm on an opening key, otherwise fall back to idle on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ULK_IDLE;
        end else if (ctrl_wr) begin
            if ((state_q == ULK_IDLE) && (key == OPEN_KEY)) begin
                state_q <= ULK_ARMED;
            end else begin
                state_q <= ULK_IDLE;
            end
        end
    end

    // R2: the armed state is only ever entered through an opening-key write.
    assert_arm_needs_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ULK_ARMED) && ($past(state_q) == ULK_IDLE)) |-> $past(ctrl_wr && (key == OPEN_KEY)));

    // R3: an accepted commit always leaves the sequencer locked.
    assert_relock_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ULK_IDLE));
endmodule

// File: rtl/pwd_wdt_prescaler.sv
// Prescaler: free-running count that yields one tick per 2^(code*STEP)
// cycles while run is high. It restarts from zero on clear or when stopped.
module pwd_wdt_prescaler #(
    parameter int  STEP   = 6,
    parameter int  CODE_W = 2,
    localparam int PRE_W  = STEP * ((1 << CODE_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    // Low bits that must all be ones for the selected division.
    always_comb begin
        span = (PRE_W+1)'(1) << (int'(code) * STEP);
        mask = PRE_W'(span - (PRE_W+1)'(1));
    end

    assign tick = run && ((pre_q | ~mask) == '1);

    // Count cycles while running, restarting on clear or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R5: any division other than one never ticks on back-to-back cycles.
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (code != '0) && !clear) |=> !tick);
endmodule

// File: rtl/pwd_wdt_counter.sv
// Countdown core: loads on commit, decrements per tick, raises the warning
// pulse and the expiry event. The reset pulse and cause flag sit in the
// power-on domain so that they outlive the system reset they request.
module pwd_wdt_counter #(
    parameter int  CNT_W      = 16,
    parameter int  CODE_W     = 2,
    parameter int  RST_CYCLES = 4,
    localparam int RC_W       = $clog2(RST_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              run,
    input  logic              tick,
    input  logic [CODE_W-1:0] warn_code,
    output logic [CNT_W-1:0]  cnt,
    output logic              warn_irq,
    output logic              expire,
    output logic              rst_req,
    output logic              cause
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [RC_W-1:0]  rst_cnt_q;
    logic             cause_q;
    logic             warn_q;

    assign limit   = CNT_W'(1) << (CNT_W - 1 - int'(warn_code));
    assign expire  = rst_n && run && tick && !load && (cnt_q <= CNT_W'(1));
    assign cnt     = cnt_q;
    assign warn_irq = warn_q;
    assign rst_req = (rst_cnt_q != '0);
    assign cause   = cause_q;

    // Load on commit, otherwise step down per tick and flag the limit crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            warn_q <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
            end else if (run && tick) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                warn_q <= (cnt_q == limit);
            end
        end
    end

    // Stretch the reset request and record the cause, power-on domain only.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_cnt_q <= '0;
            cause_q   <= 1'b0;
        end else if (expire) begin
            rst_cnt_q <= RC_W'(RST_CYCLES);
            cause_q   <= 1'b1;
        end else if (rst_cnt_q != '0) begin
            rst_cnt_q <= rst_cnt_q - RC_W'(1);
        end
    end

    // R6: the warning never lasts longer than one cycle.
    assert_warn_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);

    // R8: a stopped watchdog keeps its count until the next commit.
    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));

    // R9: expiry raises the reset request and the cause flag.
    assert_expire_flags_R9: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> (rst_req && cause));

    // R10: once set, the cause flag stays set until power-on reset.
    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);
endmodule

// File: rtl/pwd_watchdog.sv
// Top level: decodes the register bus, keeps the committed settings and
// wires the unlock sequencer, prescaler and countdown core together.
// Assumes CNT_W <= 16 so the reload field stays below the key field.
module pwd_watchdog
    import pwd_wdt_pkg::*;
#(
    parameter int  ADDR_W     = 4,
    parameter int  CNT_W      = 16,
    parameter int  PSC_STEP   = 6,
    parameter int  RST_CYCLES = 4,
    localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0),
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              warn_irq,
    output logic              rst_req
);
    logic              ctrl_wr;
    logic              accept;
    logic              tick;
    logic              expire;
    logic              cause;
    logic [CNT_W-1:0]  cnt;
    logic              en_q;
    logic [CODE_W-1:0] warn_code_q;
    logic [CODE_W-1:0] psc_code_q;
    logic [CNT_W-1:0]  reload_q;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_OFF);

    pwd_wdt_unlock #(
        .KW         (KEY_W),
        .OPEN_KEY   (KEY_OPEN),
        .COMMIT_KEY (KEY_COMMIT)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .key     (bus_wdata[KEY_LSB +: KEY_W]),
        .accept  (accept)
    );

    // Take all settings from a commit; expiry only drops the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            warn_code_q <= '0;
            psc_code_q  <= '0;
            reload_q    <= '0;
        end else if (accept) begin
            en_q        <= bus_wdata[EN_BIT];
            warn_code_q <= bus_wdata[WARN_LSB +: CODE_W];
            psc_code_q  <= bus_wdata[PSC_LSB +: CODE_W];
            reload_q    <= bus_wdata[CNT_W-1:0];
        end else if (expire) begin
            en_q <= 1'b0;
        end
    end

    pwd_wdt_prescaler #(
        .STEP   (PSC_STEP),
        .CODE_W (CODE_W)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (en_q),
        .code  (psc_code_q),
        .tick  (tick)
    );

    pwd_wdt_counter #(
        .CNT_W      (CNT_W),
        .CODE_W     (CODE_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .load      (accept),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .run       (en_q),
        .tick      (tick),
        .warn_code (warn_code_q),
        .cnt       (cnt),
        .warn_irq  (warn_irq),
        .expire    (expire),
        .rst_req   (rst_req),
        .cause     (cause)
    );

    // Read mux: settings image at the control offset, live state at status.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata[EN_BIT]                 = en_q;
            bus_rdata[WARN_LSB +: CODE_W]     = warn_code_q;
            bus_rdata[PSC_LSB +: CODE_W]      = psc_code_q;
            bus_rdata[CNT_W-1:0]              = reload_q;
        end else if (bus_addr == STAT_OFF) begin
            bus_rdata[EN_BIT]                 = en_q;
            bus_rdata[CAUSE_BIT]              = cause;
            bus_rdata[CNT_W-1:0]              = cnt;
        end
    end

    // R2: the stored reload only moves in the cycle after a commit.
    assert_reload_needs_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reload_q) |-> $past(accept));

    // R9: the running flag falls only on a commit or on expiry.
    assert_stop_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> ($past(accept) || $past(expire)));
endmodule

// File: tb/pwd_watchdog_tb.sv
// Self-checking bench: directed corner cases plus a seeded random service loop.
module pwd_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYCLES = 4;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h8;
    localparam logic [7:0] K_OPEN = 8'hBE;
    localparam logic [7:0] K_COMMIT = 8'hDC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        warn_irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwd_watchdog #(.RST_CYCLES(RST_CYCLES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .warn_irq  (warn_irq),
        .rst_req   (rst_req)
    );

    function automatic logic [31:0] cfg_word(input logic en, input logic [1:0] wc,
                                             input logic [1:0] pc, input logic [15:0] rl,
                                             input logic [7:0] key);
        return {en, 3'b000, wc, pc, key, rl};
    endfunction

    function automatic logic [31:0] ctrl_img(input logic en, input logic [1:0] wc,
                                             input logic [1:0] pc, input logic [15:0] rl);
        return cfg_word(en, wc, pc, rl, 8'h00);
    endfunction

    function automatic logic [31:0] stat_img(input logic run, input logic cs, input logic [15:0] c);
        return {run, cs, 14'b0, c};
    endfunction

    function automatic int unsigned div_of(input int code);
        return 1 << (6 * code);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic unlock_write(input logic en, input logic [1:0] wc, input logic [1:0] pc,
                                input logic [15:0] rl);
        bus_write(A_CTRL, cfg_word(en, wc, pc, rl, K_OPEN));
        bus_write(A_CTRL, cfg_word(en, wc, pc, rl, K_COMMIT));
    endtask

    task automatic check_stat(input string req, input logic run, input logic cs, input logic [15:0] c);
        logic [31:0] v;
        read_reg(A_STAT, v);
        check(req, v, stat_img(run, cs, c));
    endtask

    task automatic check_ctrl(input string req, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(A_CTRL, v);
        check(req, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] cur_rl;
        void'($urandom(32'h5EED_0007));
        @(negedge clk);
        cycles(3);
        rst_n = 1'b1;
        por_n = 1'b1;
        cycles(1);

        // R1: reset state.
        check_ctrl("R1 ctrl", 32'h0);
        check_stat("R1 status", 1'b0, 1'b0, 16'd0);
        check("R1 warn", {31'b0, warn_irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R3: commit key alone is ignored. R4: status writes are ignored.
        bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, 16'd100, K_COMMIT));
        check_ctrl("R3 lone commit", 32'h0);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        check_stat("R4 status write", 1'b0, 1'b0, 16'd0);

        // R2/R4: a proper unlock applies settings; R5 code 0 counts per cycle.
        unlock_write(1'b1, 2'd0, 2'd0, 16'd100);
        check_ctrl("R2 ctrl applied", ctrl_img(1'b1, 2'd0, 2'd0, 16'd100));
        check_stat("R4 status loaded", 1'b1, 1'b0, 16'd100);
        cycles(10);
        check_stat("R5 div1", 1'b1, 1'b0, 16'd90);

        // R8: stop holds the loaded count.
        unlock_write(1'b0, 2'd0, 2'd0, 16'd500);
        check_stat("R8 stopped", 1'b0, 1'b0, 16'd500);
        cycles(20);
        check_stat("R8 hold", 1'b0, 1'b0, 16'd500);

        // R3: wrong second key abandons, then commit without open is ignored.
        bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, 16'd7, K_OPEN));
        bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, 16'd7, 8'h12));
        bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, 16'd7, K_COMMIT));
        check_ctrl("R3 bad key", ctrl_img(1'b0, 2'd0, 2'd0, 16'd500));
        check_stat("R3 bad key status", 1'b0, 1'b0, 16'd500);
        unlock_write(1'b0, 2'd0, 2'd0, 16'd9);
        bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, 16'd33, K_COMMIT));
        check_ctrl("R3 relock", ctrl_img(1'b0, 2'd0, 2'd0, 16'd9));

        // R5: prescaler codes 1, 2 and 3.
        unlock_write(1'b1, 2'd0, 2'd1, 16'd10);
        cycles(div_of(1) - 1);
        check_stat("R5 div64 before", 1'b1, 1'b0, 16'd10);
        cycles(1);
        check_stat("R5 div64 at", 1'b1, 1'b0, 16'd9);
        unlock_write(1'b1, 2'd0, 2'd2, 16'd10);
        cycles(div_of(2) - 1);
        check_stat("R5 div4096 before", 1'b1, 1'b0, 16'd10);
        cycles(1);
        check_stat("R5 div4096 at", 1'b1, 1'b0, 16'd9);
        unlock_write(1'b1, 2'd0, 2'd3, 16'd10);
        cycles(5000);
        check_stat("R5 div262144 no tick", 1'b1, 1'b0, 16'd10);

        // R6: warning at limit 4096 (code 3) and 32768 (code 0).
        unlock_write(1'b1, 2'd3, 2'd0, 16'd4100);
        cycles(4);
        check("R6 warn before", {31'b0, warn_irq}, 32'h0);
        check_stat("R6 at limit", 1'b1, 1'b0, 16'd4096);
        cycles(1);
        check("R6 warn pulse", {31'b0, warn_irq}, 32'h1);
        cycles(1);
        check("R6 warn one cycle", {31'b0, warn_irq}, 32'h0);
        unlock_write(1'b1, 2'd0, 2'd0, 16'd32770);
        cycles(3);
        check("R6 warn code0", {31'b0, warn_irq}, 32'h1);

        // R7: service while running reloads and replaces settings.
        unlock_write(1'b1, 2'd0, 2'd0, 16'd50);
        cycles(30);
        check_stat("R7 counting", 1'b1, 1'b0, 16'd20);
        unlock_write(1'b1, 2'd0, 2'd1, 16'd50);
        check_stat("R7 reloaded", 1'b1, 1'b0, 16'd50);
        check_ctrl("R7 new settings", ctrl_img(1'b1, 2'd0, 2'd1, 16'd50));
        cycles(64);
        check_stat("R7 prescaler restarted", 1'b1, 1'b0, 16'd49);

        // R9: expiry timing and reset pulse length.
        unlock_write(1'b1, 2'd0, 2'd0, 16'd20);
        cycles(19);
        check_stat("R9 before expiry", 1'b1, 1'b0, 16'd1);
        check("R9 no req yet", {31'b0, rst_req}, 32'h0);
        cycles(1);
        check("R9 req rises", {31'b0, rst_req}, 32'h1);
        check_stat("R9 stopped with cause", 1'b0, 1'b1, 16'd0);
        cycles(RST_CYCLES - 1);
        check("R9 req held", {31'b0, rst_req}, 32'h1);
        cycles(1);
        check("R9 req released", {31'b0, rst_req}, 32'h0);

        // R10: cause survives system reset, cleared by power-on reset.
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        check_stat("R10 survives rst_n", 1'b0, 1'b1, 16'd0);
        rst_n = 1'b0;
        por_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        por_n = 1'b1;
        cycles(1);
        check_stat("R10 cleared by por_n", 1'b0, 1'b0, 16'd0);

        // R9: reload of zero expires on the first tick.
        unlock_write(1'b1, 2'd0, 2'd0, 16'd0);
        check("R9 zero reload wait", {31'b0, rst_req}, 32'h0);
        cycles(1);
        check("R9 zero reload req", {31'b0, rst_req}, 32'h1);
        check_stat("R9 zero reload status", 1'b0, 1'b1, 16'd0);
        por_n = 1'b0;
        rst_n = 1'b0;
        cycles(2);
        por_n = 1'b1;
        rst_n = 1'b1;
        cycles(1);

        // R7/R3: seeded random services with occasional broken handshakes.
        cur_rl = 16'd0;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] rl;
            int unsigned w;
            rl = 16'(400 + $urandom_range(1000));
            w  = $urandom_range(300);
            if ($urandom_range(3) == 0) begin
                logic [7:0] bad;
                bad = 8'($urandom_range(255));
                if (bad == K_COMMIT) bad = 8'h00;
                bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, rl, K_OPEN));
                bus_write(A_CTRL, cfg_word(1'b1, 2'd0, 2'd0, rl, bad));
                check_ctrl("R3 random bad key", ctrl_img(i != 0, 2'd0, 2'd0, cur_rl));
            end
            unlock_write(1'b1, 2'd0, 2'd0, rl);
            cycles(w);
            check_stat("R7 random service", 1'b1, 1'b0, rl - 16'(w));
            cur_rl = rl;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule